// File: doc/BRIEF.md
# Selectable Input Conditioning Bank

This block takes sixteen raw, asynchronous input lines and hands sixteen conditioned lines to downstream logic. Each line has its own conditioner. A 3-bit mode field, one per channel, can be changed at run time. It picks what the channel delivers:

- the input brought safely into the local clock domain;
- the raw input with no clocking at all;
- a one-clock pulse when the input rises;
- a one-clock pulse when the input falls.

Only four of the eight codes carry a meaning. The rest fall back to the safe synchronized behaviour.

Every channel runs a two-flop synchronizer and a one-flop edge history all the time, whatever its mode. A mode change therefore switches only an output selector, never the state behind it. Edge pulses come from comparing the synchronized level with its value one clock earlier. A shared arming counter masks edge pulses for the first few clocks after reset. A level held steady through reset can therefore never look like an edge. There is no handshake on either side: the outputs are plain level and pulse signals and are never back-pressured.

Top module: `input_cond_bank`

## Requirements
- R1: The bank has 16 channels. Channel i is driven only by `raw_in[i]` and by its own mode field `mode_cfg[3*i+2:3*i]`, and it drives only `cond_out[i]`.
- R2: Code 3'b000 (synchronized): `cond_out[i]` equals the value `raw_in[i]` had at the clock edge two edges earlier.
- R3: Code 3'b001 (direct): `cond_out[i]` follows `raw_in[i]` combinationally, with no clock delay, also while reset is active.
- R4: Code 3'b010 (rising edge): suppose `raw_in[i]` is sampled low at edge k-1 and high at edge k. Then `cond_out[i]` is high from edge k+1 to edge k+2, and low at all other times unless another such transition occurs.
- R5: Code 3'b011 (falling edge): the same as R4 with high and low swapped on the input. The output pulse is still active high.
- R6: Codes 3'b100 to 3'b111 behave exactly as code 3'b000.
- R7: While `rst_n` is low, every synchronizer and history flop is cleared, and every channel not in direct mode outputs 0.
- R8: Edge pulses are masked until three clock edges have passed after reset release. An input held at a constant level across reset never produces a pulse.
- R9: A mode change does not disturb the channel's synchronizer or history. Entering synchronized mode shows the current synchronized level at once. Entering an edge mode while the input is steady gives no pulse.
- R10: An edge pulse lasts exactly one clock, even when the input then stays at its new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 16 | Raw asynchronous input lines, one per channel |
| mode_cfg | input | 48 | Per-channel 3-bit mode fields; channel i at bits [3i+2:3i] |
| cond_out | output | 16 | Conditioned outputs, one per channel |

## Verification
The input patterns cover three cases:

- **Isolated single transitions** on one channel. These separate the rising and falling pulses from the synchronized level and measure the two-edge latency exactly.
- **Levels held high or low through reset and across mode changes.** These tell genuine edges apart from artefacts of reset release or of switching the selector.
- **Long random runs** with sparse toggles and per-channel random codes, including the undefined ones. These mix all modes across neighbouring channels at once, which exposes field-position mistakes and cross-channel leakage.

A reference model in the bench, advanced once per clock, supplies the expected value of every channel in every cycle.

// File: rtl/icb_pkg.sv
package icb_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SYNC   = 3'b000,
    MODE_DIRECT = 3'b001,
    MODE_RISE   = 3'b010,
    MODE_FALL   = 3'b011
  } cond_mode_e;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } cond_taps_t;

  // Undefined codes (MSB set) fold onto the synchronized mode.
  function automatic cond_mode_e decode_mode(input logic [MODE_W-1:0] code);
    cond_mode_e m;
    if (code[MODE_W-1]) begin
      m = MODE_SYNC;
    end else begin
      unique case (code[1:0])
        2'b00:   m = MODE_SYNC;
        2'b01:   m = MODE_DIRECT;
        2'b10:   m = MODE_RISE;
        default: m = MODE_FALL;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/icb_sync.sv
module icb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/icb_arm.sv
module icb_arm #(
  parameter int ARM_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);

  localparam int CNT_W = $clog2(ARM_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != CNT_W'(ARM_CYC)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign armed = (cnt == CNT_W'(ARM_CYC));

endmodule

// File: rtl/icb_edge.sv
module icb_edge
  import icb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic       armed,
  output cond_taps_t taps
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  always_comb begin
    taps.level = level;
    taps.rise  = armed &  level & ~prev;
    taps.fall  = armed & ~level &  prev;
  end

endmodule

// File: rtl/icb_chan.sv
module icb_chan
  import icb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw,
  input  logic [MODE_W-1:0] code,
  input  logic              armed,
  output logic              out
);

  logic       level;
  cond_taps_t taps;
  cond_mode_e mode;

  icb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (level)
  );

  icb_edge edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (level),
    .armed (armed),
    .taps  (taps)
  );

  assign mode = decode_mode(code);

  always_comb begin
    unique case (mode)
      MODE_DIRECT: out = raw;
      MODE_RISE:   out = taps.rise;
      MODE_FALL:   out = taps.fall;
      default:     out = taps.level;
    endcase
  end

endmodule

// File: rtl/input_cond_bank.sv
module input_cond_bank
  import icb_pkg::*;
#(
  parameter int CHANNELS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CHANNELS-1:0]          raw_in,
  input  logic [CHANNELS*MODE_W-1:0]   mode_cfg,
  output logic [CHANNELS-1:0]          cond_out
);

  localparam int ARM_CYC = SYNC_STAGES + 1;

  logic armed;

  icb_arm #(.ARM_CYC(ARM_CYC)) arm_i (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed)
  );

  generate
    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
      icb_chan #(.SYNC_STAGES(SYNC_STAGES)) chan_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_in[i]),
        .code  (mode_cfg[i*MODE_W +: MODE_W]),
        .armed (armed),
        .out   (cond_out[i])
      );
    end
  endgenerate

endmodule

// File: rtl/input_cond_bank_chk.sv
module input_cond_bank_chk #(
  parameter int CHANNELS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CHANNELS-1:0]        raw_in,
  input logic [CHANNELS*MODE_W-1:0] mode_cfg,
  input logic [CHANNELS-1:0]        cond_out
);

  localparam int LIM   = SYNC_STAGES + 2;
  localparam int CYC_W = $clog2(LIM + 1);

  logic [CYC_W-1:0]                 cyc;
  logic [SYNC_STAGES:0][CHANNELS-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      hist <= '0;
    end else begin
      if (cyc != CYC_W'(LIM)) cyc <= cyc + 1'b1;
      hist <= {hist[SYNC_STAGES-1:0], raw_in};
    end
  end

  generate
    for (genvar i = 0; i < CHANNELS; i++) begin : g_ap
      logic [MODE_W-1:0] c;
      assign c = mode_cfg[i*MODE_W +: MODE_W];

      p_sync_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= CYC_W'(SYNC_STAGES) && c == 3'b000) |-> cond_out[i] == hist[SYNC_STAGES-1][i]);

      p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 3'b001) |-> cond_out[i] == raw_in[i]);

      p_rise_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 3'b010 && cond_out[i]) |->
          (cyc > CYC_W'(SYNC_STAGES) && hist[SYNC_STAGES-1][i] && !hist[SYNC_STAGES][i]));

      p_fall_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 3'b011 && cond_out[i]) |->
          (cyc > CYC_W'(SYNC_STAGES) && !hist[SYNC_STAGES-1][i] && hist[SYNC_STAGES][i]));

      p_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= CYC_W'(SYNC_STAGES) && c[MODE_W-1]) |-> cond_out[i] == hist[SYNC_STAGES-1][i]);

      p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc <= CYC_W'(SYNC_STAGES) && (c == 3'b010 || c == 3'b011)) |-> !cond_out[i]);

      p_one_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((c == 3'b010 || c == 3'b011) && cond_out[i]) |=> !(cond_out[i] && c == $past(c)));
    end
  endgenerate

endmodule

bind input_cond_bank input_cond_bank_chk #(
  .CHANNELS    (CHANNELS),
  .SYNC_STAGES (SYNC_STAGES),
  .MODE_W      (icb_pkg::MODE_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .raw_in   (raw_in),
  .mode_cfg (mode_cfg),
  .cond_out (cond_out)
);

// File: tb/input_cond_bank_tb_top.sv
module input_cond_bank_tb_top;

  localparam int CH  = 16;
  localparam int SS  = 2;
  localparam int MW  = 3;
  localparam int ARM = SS + 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CH-1:0]    raw_in;
  logic [CH*MW-1:0] mode_cfg;
  logic [CH-1:0]    cond_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model
  logic [SS-1:0][CH-1:0] m_sync;
  logic [CH-1:0]         m_prev;
  int                    m_cnt;

  always #5 clk = ~clk;

  input_cond_bank #(.CHANNELS(CH), .SYNC_STAGES(SS)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_in),
    .mode_cfg (mode_cfg),
    .cond_out (cond_out)
  );

  function automatic logic exp_bit(int i);
    logic [MW-1:0] c;
    logic lvl;
    logic armed;
    c     = mode_cfg[i*MW +: MW];
    lvl   = m_sync[SS-1][i];
    armed = (m_cnt >= ARM);
    if (c == 3'b001) return raw_in[i];
    if (c == 3'b010) return armed & lvl & ~m_prev[i];
    if (c == 3'b011) return armed & ~lvl & m_prev[i];
    return lvl;
  endfunction

  function automatic string tag_of(int i);
    logic [MW-1:0] c;
    c = mode_cfg[i*MW +: MW];
    if (c == 3'b001) return "R3";
    if (!rst_n) return "R7";
    if ((c == 3'b010 || c == 3'b011) && m_cnt < ARM) return "R8";
    if (c == 3'b010) return "R4";
    if (c == 3'b011) return "R5";
    if (c[2]) return "R6";
    return "R2";
  endfunction

  task automatic model_clear();
    m_sync = '0;
    m_prev = '0;
    m_cnt  = 0;
  endtask

  task automatic model_advance();
    m_prev = m_sync[SS-1];
    for (int k = SS-1; k > 0; k--) m_sync[k] = m_sync[k-1];
    m_sync[0] = raw_in;
    if (m_cnt < ARM) m_cnt++;
  endtask

  task automatic compare_all(input string force_tag);
    for (int i = 0; i < CH; i++) begin
      logic e;
      string t;
      e = exp_bit(i);
      t = (force_tag != "") ? force_tag : tag_of(i);
      n_chk++;
      if (cond_out[i] !== e) begin
        n_fail++;
        $display("FAIL %s ch%0d mode=%b got=%b exp=%b t=%0t",
                 t, i, mode_cfg[i*MW +: MW], cond_out[i], e, $time);
      end
    end
  endtask

  task automatic step(input logic rst, input logic [CH-1:0] raw,
                      input logic [CH*MW-1:0] mode, input string force_tag);
    @(negedge clk);
    rst_n    = rst;
    raw_in   = raw;
    mode_cfg = mode;
    if (!rst) model_clear();
    #1 compare_all(force_tag);
    @(posedge clk);
    #1 if (rst_n) model_advance();
  endtask

  function automatic logic [CH*MW-1:0] all_mode(logic [MW-1:0] c);
    logic [CH*MW-1:0] m;
    for (int i = 0; i < CH; i++) m[i*MW +: MW] = c;
    return m;
  endfunction

  function automatic logic [CH*MW-1:0] rand_modes();
    logic [CH*MW-1:0] m;
    for (int i = 0; i < CH; i++) m[i*MW +: MW] = MW'($urandom_range(0, 7));
    return m;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0]    r;
    logic [CH*MW-1:0] m;
    void'($urandom(32'd4242));
    rst_n    = 1'b0;
    raw_in   = '0;
    mode_cfg = '0;
    model_clear();

    // R7 / R3: reset state with mixed modes and random inputs
    m = all_mode(3'b000);
    m[0 +: MW] = 3'b001; m[3 +: MW] = 3'b010; m[6 +: MW] = 3'b011; m[9 +: MW] = 3'b101;
    for (int n = 0; n < 6; n++) step(1'b0, CH'($urandom), m, "");

    // R8: levels held high through reset on even channels, edge modes everywhere
    m = all_mode(3'b010);
    for (int i = 1; i < CH; i += 2) m[i*MW +: MW] = 3'b011;
    step(1'b0, 16'h5555, m, "R8");
    for (int n = 0; n < 8; n++) step(1'b1, 16'h5555, m, "R8");

    // R4 / R10: one rising transition on a rise-mode channel, then hold high
    m = all_mode(3'b000); m[2*MW +: MW] = 3'b010;
    for (int n = 0; n < 3; n++) step(1'b1, 16'h0000, m, "");
    for (int n = 0; n < 8; n++) step(1'b1, 16'h0004, m, "R10");
    // R5: falling transition on a fall-mode channel
    m[2*MW +: MW] = 3'b011;
    for (int n = 0; n < 8; n++) step(1'b1, 16'h0000, m, "R5");

    // R9: steady high, switch sync -> rise -> fall -> sync
    for (int n = 0; n < 4; n++) step(1'b1, 16'hFFFF, all_mode(3'b000), "R9");
    for (int n = 0; n < 3; n++) step(1'b1, 16'hFFFF, all_mode(3'b010), "R9");
    for (int n = 0; n < 3; n++) step(1'b1, 16'hFFFF, all_mode(3'b011), "R9");
    step(1'b1, 16'hFFFF, all_mode(3'b110), "R9");

    // R1: only channel 7 direct, only its input toggles; the rest must stay put
    m = all_mode(3'b000); m[7*MW +: MW] = 3'b001;
    for (int n = 0; n < 6; n++) step(1'b1, 16'hFF7F | (CH'(n & 1) << 7), m, "R1");

    // random run with sparse toggles and periodic mode reshuffles
    r = CH'($urandom);
    m = rand_modes();
    for (int n = 0; n < 4000; n++) begin
      if (n % 40 == 0) m = rand_modes();
      r = r ^ (CH'($urandom) & CH'($urandom) & CH'($urandom));
      if (n == 2000) begin
        step(1'b0, r, m, "R7");
        step(1'b0, r, m, "R7");
      end
      step(1'b1, r, m, "");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule